// File: doc/BRIEF.md
# Packed SIMD Integer Multiply Unit

This block multiplies two 64-bit operand words lane by lane, where the lanes are 8, 16, 32 or 64 bits wide. The first operand always comes from a vector source. The second comes either from a second vector source or from a scalar whose low element is copied into every lane. Each result lane is one element wide. It holds either the low half of the double-width product or one of three high halves: signed by signed, unsigned by unsigned, or signed (first operand) by unsigned (second operand).

The operation is decoded from a 32-bit instruction word. A per-lane mask can hold selected lanes at their previous destination value, which is supplied on its own input. The result is registered one cycle after a request. A three-state controller (`ST_IDLE`, `ST_RESULT`, `ST_REJECT`) marks that cycle as a valid result or as a rejected operation. Its transitions are: any state goes to `ST_RESULT` on a legal request, to `ST_REJECT` on a request with the right major opcode but an unknown operation, and back to `ST_IDLE` when there is no accepted request.

Top module: `smu_mul_unit`

## Requirements
- R1: A request is decoded only when insn[6:0] is 1010111. Field insn[14:12] selects the second operand: 010 takes `src_b`, and 110 takes the low element of `scalar` copied into every lane.
- R2: Operation code insn[31:26] = 100101 returns the low element-width bits of each lane product.
- R3: Operation code 100111 returns the upper element-width bits of the product, with both operands treated as signed.
- R4: Operation code 100100 returns the upper element-width bits of the product, with both operands treated as unsigned.
- R5: Operation code 100110 returns the upper element-width bits of the product, with `src_a` treated as signed and the second operand treated as unsigned. This includes the 64-bit width.
- R6: `ew_sel` sets the element width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Lane i occupies bits [i*W +: W] of every operand and of the result.
- R7: insn[25] is the mask-enable bit. When it is 0, each lane i whose `mask_bits[i]` is 0 returns lane i of `old_dest`. When it is 1, every lane is written.
- R8: A request with opcode 1010111 and any other combination of insn[31:26] and insn[14:12] raises `illegal` for one cycle. In that cycle `out_valid` stays low and `out_data` is unchanged.
- R9: `out_valid` is high for exactly the one cycle after each legal request, and `out_data` carries that request's result in that cycle.
- R10: Synchronous active-high `rst` clears `out_valid`, `illegal` and `out_data`.
- R11: A request with any other major opcode is ignored. `out_valid` and `illegal` stay low and `out_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| insn | input | 32 | Instruction word |
| ew_sel | input | 2 | Element width code |
| src_a | input | 64 | First vector operand (the signed side in mixed mode) |
| src_b | input | 64 | Second vector operand |
| scalar | input | 64 | Scalar operand for broadcast |
| old_dest | input | 64 | Previous destination word, used for masked-off lanes |
| mask_bits | input | 8 | Per-lane mask, bit i for lane i |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Result word |
| illegal | output | 1 | Rejected operation flag |

## Verification
Directed cases multiply the most negative element by itself and by the all-ones pattern, and use zero operands, in every mode and at every width. These cases separate signed from unsigned sign handling and show whether a correction is applied to the wrong operand. Random operands, widths, modes, operand sources and masks are compared against a reference that uses 128-bit arithmetic. The random runs separate the lane boundaries, the broadcast source and the mask merge. Separate cases check rejected and foreign-opcode requests: the result word must hold its last value, and `illegal` must rise only for the reject case.

// File: rtl/smu_pkg.sv
package smu_pkg;
    localparam int XLEN   = 64;
    localparam int MASK_W = XLEN / 8;

    localparam logic [6:0] MAJOR_OP  = 7'b1010111;
    localparam logic [2:0] SRC_VEC   = 3'b010;
    localparam logic [2:0] SRC_SCAL  = 3'b110;
    localparam logic [5:0] F6_LO     = 6'b100101;
    localparam logic [5:0] F6_HSS    = 6'b100111;
    localparam logic [5:0] F6_HUU    = 6'b100100;
    localparam logic [5:0] F6_HSU    = 6'b100110;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ew_t;

    typedef enum logic [1:0] {
        MOP_LO  = 2'd0,
        MOP_HSS = 2'd1,
        MOP_HUU = 2'd2,
        MOP_HSU = 2'd3
    } mul_op_t;

    typedef struct packed {
        logic    hit;
        logic    legal;
        mul_op_t op;
        logic    use_scalar;
        logic    vm;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_REJECT = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/smu_decode.sv
module smu_decode
    import smu_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);
    logic [5:0] f6;
    logic [2:0] f3;
    logic       f6_ok;
    logic       f3_ok;
    mul_op_t    op_sel;

    assign f6 = insn[31:26];
    assign f3 = insn[14:12];

    always_comb begin
        f6_ok  = 1'b1;
        op_sel = MOP_LO;
        unique case (f6)
            F6_LO:   op_sel = MOP_LO;
            F6_HSS:  op_sel = MOP_HSS;
            F6_HUU:  op_sel = MOP_HUU;
            F6_HSU:  op_sel = MOP_HSU;
            default: f6_ok  = 1'b0;
        endcase
    end

    assign f3_ok = (f3 == SRC_VEC) || (f3 == SRC_SCAL);

    always_comb begin
        dec.hit        = (insn[6:0] == MAJOR_OP);
        dec.legal      = dec.hit && f6_ok && f3_ok;
        dec.op         = op_sel;
        dec.use_scalar = (f3 == SRC_SCAL);
        dec.vm         = insn[25];
    end
endmodule

// File: rtl/smu_lane.sv
module smu_lane
    import smu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  mul_op_t      op,
    output logic [W-1:0] r
);
    localparam int PW = 2 * W;

    logic [PW-1:0] uprod;
    logic [W-1:0]  hi;
    logic          fix_a;
    logic          fix_b;

    assign uprod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    // Signed operands are rebuilt from the unsigned product by subtracting
    // the other operand from the upper half for each negative side.
    always_comb begin
        fix_a = a[W-1] && ((op == MOP_HSS) || (op == MOP_HSU));
        fix_b = b[W-1] && (op == MOP_HSS);
        hi    = uprod[PW-1:W];
        if (fix_a) hi = hi - b;
        if (fix_b) hi = hi - a;
        r = (op == MOP_LO) ? uprod[W-1:0] : hi;
    end
endmodule

// File: rtl/smu_lane_group.sv
module smu_lane_group
    import smu_pkg::*;
#(
    parameter int W    = 8,
    parameter int DATW = 64
) (
    input  logic [DATW-1:0]     src_a,
    input  logic [DATW-1:0]     src_b,
    input  logic [DATW-1:0]     scalar,
    input  logic [DATW-1:0]     old_dest,
    input  logic [DATW/8-1:0]   mask_bits,
    input  logic                use_scalar,
    input  logic                vm,
    input  mul_op_t             op,
    output logic [DATW-1:0]     word
);
    localparam int LANES = DATW / W;

    logic [DATW-1:0] opnd_b;
    logic [DATW-1:0] raw;

    assign opnd_b = use_scalar ? {LANES{scalar[W-1:0]}} : src_b;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        smu_lane #(.W(W)) u_lane (
            .a  (src_a[i*W +: W]),
            .b  (opnd_b[i*W +: W]),
            .op (op),
            .r  (raw[i*W +: W])
        );
        assign word[i*W +: W] = (vm || mask_bits[i]) ? raw[i*W +: W]
                                                     : old_dest[i*W +: W];
    end

    if (LANES < DATW / 8) begin : g_unused
        logic unused_mask;
        assign unused_mask = ^mask_bits[DATW/8-1:LANES];
    end
endmodule

// File: rtl/smu_mul_unit.sv
module smu_mul_unit
    import smu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] insn,
    input  logic [1:0]  ew_sel,
    input  logic [63:0] src_a,
    input  logic [63:0] src_b,
    input  logic [63:0] scalar,
    input  logic [63:0] old_dest,
    input  logic [7:0]  mask_bits,
    output logic        out_valid,
    output logic [63:0] out_data,
    output logic        illegal
);
    localparam int NW = 4;

    dec_t            dec;
    ctl_state_t      state_q;
    ctl_state_t      state_d;
    logic [XLEN-1:0] grp_word [NW];
    logic [XLEN-1:0] sel_word;
    logic            accept;

    smu_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    for (genvar g = 0; g < NW; g++) begin : g_width
        smu_lane_group #(.W(8 << g), .DATW(XLEN)) u_grp (
            .src_a      (src_a),
            .src_b      (src_b),
            .scalar     (scalar),
            .old_dest   (old_dest),
            .mask_bits  (mask_bits),
            .use_scalar (dec.use_scalar),
            .vm         (dec.vm),
            .op         (dec.op),
            .word       (grp_word[g])
        );
    end

    always_comb begin
        unique case (ew_t'(ew_sel))
            EW_8:    sel_word = grp_word[0];
            EW_16:   sel_word = grp_word[1];
            EW_32:   sel_word = grp_word[2];
            EW_64:   sel_word = grp_word[3];
            default: sel_word = grp_word[0];
        endcase
    end

    assign accept = req_valid && dec.legal;

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid && dec.hit) begin
            state_d = dec.legal ? ST_RESULT : ST_REJECT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)         out_data <= '0;
        else if (accept) out_data <= sel_word;
    end

    always_comb begin
        out_valid = 1'b0;
        illegal   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: out_valid = 1'b1;
            ST_REJECT: illegal   = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/smu_mul_checker.sv
module smu_mul_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] insn,
    input logic [1:0]  ew_sel,
    input logic [63:0] old_dest,
    input logic [7:0]  mask_bits,
    input logic        out_valid,
    input logic [63:0] out_data,
    input logic        illegal
);
    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && !illegal && out_data == 64'd0));

    assert_valid_cause_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(req_valid));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && illegal));

    assert_reject_holds_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $stable(out_data));

    assert_foreign_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && insn[6:0] != 7'b1010111) |=> (!out_valid && !illegal && $stable(out_data)));

    assert_masked_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(insn[25] == 1'b0 && ew_sel == 2'd3 && !mask_bits[0]))
        |-> (out_data == $past(old_dest)));
endmodule

bind smu_mul_unit smu_mul_checker u_chk (.*);

// File: tb/smu_mul_unit_test.sv
`timescale 1ns/1ps
module smu_mul_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [1:0]  ew_sel = '0;
    logic [63:0] src_a = '0, src_b = '0, scalar = '0, old_dest = '0;
    logic [7:0]  mask_bits = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        illegal;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    smu_mul_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .insn(insn), .ew_sel(ew_sel),
        .src_a(src_a), .src_b(src_b), .scalar(scalar), .old_dest(old_dest),
        .mask_bits(mask_bits), .out_valid(out_valid), .out_data(out_data),
        .illegal(illegal)
    );

    localparam logic [5:0] F6S [4] = '{6'b100101, 6'b100111, 6'b100100, 6'b100110};

    function automatic logic [31:0] mk_insn(logic [5:0] f6, logic vm, logic [2:0] f3);
        return {f6, vm, 5'd2, 5'd1, f3, 5'd3, 7'b1010111};
    endfunction

    // mode: 0 low, 1 signed*signed, 2 unsigned*unsigned, 3 signed*unsigned
    function automatic logic [63:0] ref_lane(logic [63:0] a, logic [63:0] b,
                                             int w, int mode);
        logic [127:0] ea, eb, p, wm;
        wm = (w == 64) ? 128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF
                       : ((128'd1 << w) - 128'd1);
        ea = {64'd0, a} & wm;
        eb = {64'd0, b} & wm;
        if ((mode == 1 || mode == 3) && a[w-1]) ea = ea - (128'd1 << w);
        if (mode == 1 && b[w-1])                eb = eb - (128'd1 << w);
        p = ea * eb;
        if (mode == 0) return 64'(p & wm);
        return 64'((p >> w) & wm);
    endfunction

    function automatic logic [63:0] ref_word(logic [63:0] a, logic [63:0] b,
            logic [63:0] s, logic [63:0] old, logic [7:0] m, int ew, int mode,
            bit scal, bit vm);
        int w = 8 << ew;
        logic [63:0] res = '0;
        logic [63:0] wm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        for (int i = 0; i < 64 / w; i++) begin
            logic [63:0] la = (a >> (i * w)) & wm;
            logic [63:0] lb = scal ? (s & wm) : ((b >> (i * w)) & wm);
            logic [63:0] lr = (vm || m[i]) ? ref_lane(la, lb, w, mode)
                                           : ((old >> (i * w)) & wm);
            res = res | (lr << (i * w));
        end
        return res;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(int ew, int mode, bit scal, bit vm, logic [7:0] m,
                          logic [63:0] a, logic [63:0] b, logic [63:0] s,
                          logic [63:0] old, string req);
        logic [63:0] exp;
        exp = ref_word(a, b, s, old, m, ew, mode, scal, vm);
        @(negedge clk);
        req_valid = 1'b1;
        insn = mk_insn(F6S[mode], vm, scal ? 3'b110 : 3'b010);
        ew_sel = 2'(ew); src_a = a; src_b = b; scalar = s; old_dest = old; mask_bits = m;
        @(negedge clk);
        req_valid = 1'b0;
        chk(out_valid === 1'b1 && illegal === 1'b0, {req, " R9 valid"},
            {62'd0, illegal, out_valid}, 64'd1);
        chk(out_data === exp, req, out_data, exp);
        @(negedge clk);
        chk(out_valid === 1'b0, "R9 single pulse", {63'd0, out_valid}, 64'd0);
    endtask

    function automatic logic [63:0] rep(logic [63:0] pat, int ew);
        int w = 8 << ew;
        logic [63:0] r = '0;
        for (int i = 0; i < 64 / w; i++) r = r | ((pat & ((w == 64) ? '1 : ((64'd1 << w) - 64'd1))) << (i * w));
        return r;
    endfunction

    initial begin
        #(5 * 200000);
        $display("FAIL watchdog expired actual=running expected=finished");
        n_checks++;
        n_fail++;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] held;
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk(out_valid === 0 && illegal === 0 && out_data === 0, "R10 reset",
            out_data, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // Directed corner cases per width and mode
        for (int ew = 0; ew < 4; ew++) begin
            int w = 8 << ew;
            logic [63:0] mn = rep(64'd1 << (w - 1), ew);
            for (int md = 0; md < 4; md++) begin
                run_op(ew, md, 0, 1, 8'h00, mn, mn, 0, 0, md == 0 ? "R2 R6 min*min" :
                       md == 1 ? "R3 R6 min*min" : md == 2 ? "R4 R6 min*min" : "R5 R6 min*min");
                run_op(ew, md, 0, 1, 8'h00, mn, '1, 0, 0, "R5 R3 R4 min*ones");
                run_op(ew, md, 0, 1, 8'h00, '1, mn, 0, 0, "R5 ones*min");
                run_op(ew, md, 0, 1, 8'h00, 64'd0, {$urandom, $urandom}, 0, 0, "R2 R6 zero");
            end
            run_op(ew, 3, 1, 1, 8'h00, mn, 0, '1, 0, "R1 R5 scalar ones");
        end

        // Mask merge
        run_op(3, 0, 0, 0, 8'h00, 64'd7, 64'd9, 0, 64'hDEAD_BEEF_0123_4567, "R7 masked 64");
        run_op(0, 1, 0, 0, 8'hA5, 64'h8081_7F02_FF10_0305, 64'h0203_0405_0607_0809,
               0, 64'h1111_2222_3333_4444, "R7 partial mask 8");

        // Random
        for (int k = 0; k < 400; k++) begin
            int ew = $urandom % 4;
            int md = $urandom % 4;
            bit sc = $urandom % 2;
            bit vm = $urandom % 2;
            run_op(ew, md, sc, vm, 8'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                   {$urandom, $urandom}, {$urandom, $urandom}, "R1 R6 R7 random");
        end

        // Illegal combination
        held = out_data;
        @(negedge clk);
        req_valid = 1'b1;
        insn = mk_insn(6'b000000, 1, 3'b010);
        @(negedge clk);
        req_valid = 1'b0;
        chk(illegal === 1 && out_valid === 0, "R8 flag", {62'd0, illegal, out_valid}, 64'd2);
        chk(out_data === held, "R8 hold", out_data, held);
        @(negedge clk);
        req_valid = 1'b1;
        insn = mk_insn(6'b100101, 1, 3'b000);
        @(negedge clk);
        req_valid = 1'b0;
        chk(illegal === 1 && out_valid === 0, "R8 bad source", {62'd0, illegal, out_valid}, 64'd2);
        chk(out_data === held, "R8 hold 2", out_data, held);

        // Foreign opcode
        @(negedge clk);
        req_valid = 1'b1;
        insn = {mk_insn(6'b100101, 1, 3'b010)} ^ 32'h1;
        src_a = 64'd3; src_b = 64'd5;
        @(negedge clk);
        req_valid = 1'b0;
        chk(illegal === 0 && out_valid === 0, "R11 ignored", {62'd0, illegal, out_valid}, 64'd0);
        chk(out_data === held, "R11 hold", out_data, held);

        // Reset mid-run
        run_op(2, 0, 0, 1, 0, 64'd6, 64'd7, 0, 0, "R2 before reset");
        rst = 1'b1;
        @(negedge clk);
        chk(out_valid === 0 && illegal === 0 && out_data === 0, "R10 reset again",
            out_data, 64'd0);
        rst = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule